// File: doc/BRIEF.md
# Lock-Guarded Control Register Bank

This block holds the control registers of one peripheral behind a simple single-cycle bus-slave port. The port has a byte address, 32-bit write data, four byte enables, separate read and write strobes, and registered read data. Four registers sit at word offsets 0x0, 0x4, 0x8 and 0xC. A lock register at offset 0x10 protects the two registers at 0x8 and 0xC: a write to either one lands only if the bus access just before it was an unlock write to that lock register. The lock register belongs to this bank alone.

Every register keeps unused bit positions as reserved. Reserved bits always read zero and ignore writes. Each write updates only the byte lanes whose enables are set. The address is only partly decoded, so the whole register set repeats every 32 bytes. There are two active-low resets. The soft reset returns every register to its default except the one at 0xC. The power-on reset clears everything, including that register.

Top module: `locked_regbank`

## Requirements
- R1: While either reset is low, and after it is released, registers 0x0/0x4/0x8 read 0x0000_00A5, 0x0000_0F00 and 0x0000_0001, no unlock is pending, and read data is zero.
- R2: Register 0xC keeps its value across a soft reset (`rst_soft_n`). The power-on reset (`rst_por_n`) sets it to 0x0000_0010.
- R3: The writable bits are 0x0000_FFFF at 0x0, 0xFF00_FF0F at 0x4, 0x0000_03FF at 0x8 and 0x0000_00FF at 0xC. All other bits read zero and ignore writes.
- R4: A write changes only the bytes whose `bus_be` bit is set. Bit k enables data bits 8k+7..8k.
- R5: An unlock is a write with all four byte enables set and data 0x0000_00AA to offset 0x10. A write to 0x8 or 0xC takes effect only when the access just before it was an unlock.
- R6: Any access that is not itself an unlock clears a pending unlock. This includes a read, a write to any offset, or a non-unlock write to 0x10. The next write always uses up the unlock. Writes to 0x0 and 0x4 always take effect.
- R7: Reading offset 0x10 returns 1 in bit 0 if an unlock was pending when the read was issued, and 0 otherwise. All other bits read zero.
- R8: Offsets 0x14, 0x18 and 0x1C hold no register. Writes there are dropped and reads return zero.
- R9: Only address bits [4:2] are decoded. Any address with the same bits [4:2] reaches the same register.
- R10: Read data is registered. It appears on the cycle after `bus_rd` and holds until the next read.
- R11: If `bus_rd` and `bus_wr` are both high in one cycle, this counts as one access. The write is performed, and the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_soft_n | input | 1 | Soft reset, active low; does not clear the 0xC register |
| rst_por_n | input | 1 | Power-on reset, active low; clears everything |
| bus_addr | input | 12 | Byte address inside the peripheral window |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 32 | Registered read data |

## Verification
Two functions can land in the same cycle: a read and a write. When they share a cycle, they form one access, and that access also uses up or cancels a pending unlock. The random phase drives both strobes at once on about a quarter of cycles. It includes same-cycle read/write to the lock register and to locked registers just after an unlock. A reference model updates its registers and pending flag only after forming the read value from the state before the access. The bench then compares the registered read data and later readbacks against that model.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int NREG       = 4;
    localparam int LOCK_SLOT  = 4;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_00AA;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BE_W-1:0]   lanes_t;

    // Expand byte enables into a bit mask.
    function automatic word_t lane_mask(input lanes_t be);
        word_t m;
        for (int k = 0; k < BE_W; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

    // Writable (non-reserved) bits of each register.
    function automatic word_t reg_wmask(input int idx);
        case (idx)
            0:       return 32'h0000_FFFF;
            1:       return 32'hFF00_FF0F;
            2:       return 32'h0000_03FF;
            3:       return 32'h0000_00FF;
            default: return '0;
        endcase
    endfunction

    function automatic word_t reg_default(input int idx);
        case (idx)
            0:       return 32'h0000_00A5;
            1:       return 32'h0000_0F00;
            2:       return 32'h0000_0001;
            3:       return 32'h0000_0010;
            default: return '0;
        endcase
    endfunction

    function automatic bit reg_guarded(input int idx);
        return (idx == 2) || (idx == 3);
    endfunction

    // Registers that only the power-on reset clears.
    function automatic bit reg_por_only(input int idx);
        return (idx == 3);
    endfunction

endpackage

// File: rtl/lrb_decode.sv
module lrb_decode
    import lrb_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  word_t             wdata,
    input  lanes_t            be,
    output logic [IDX_W-1:0]  idx,
    output logic [NREG-1:0]   reg_sel,
    output logic              unlock_hit
);

    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:IDX_LSB+IDX_W], addr[IDX_LSB-1:0]};

    assign idx = addr[IDX_LSB +: IDX_W];

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign reg_sel[g] = (idx == IDX_W'(g));
    end

    assign unlock_hit = wr && (idx == IDX_W'(LOCK_SLOT))
                        && (wdata == UNLOCK_KEY) && (&be);

endmodule

// File: rtl/lrb_lock.sv
module lrb_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic unlock_hit,
    output logic pend_q
);

    typedef struct packed {
        logic pend;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (access) begin
            st_d.pend = unlock_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;

endmodule

// File: rtl/lrb_field.sv
module lrb_field
    import lrb_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic   clk,
    input  logic   rst_soft_n,
    input  logic   rst_por_n,
    input  logic   we,
    input  lanes_t be,
    input  word_t  wdata,
    output word_t  val_q
);

    localparam word_t WMASK    = reg_wmask(IDX);
    localparam word_t DEF_VAL  = reg_default(IDX);
    localparam bit    POR_ONLY = reg_por_only(IDX);

    typedef struct packed {
        word_t val;
    } fld_st_t;

    fld_st_t st_d, st_q;
    logic    rst_n;
    word_t   bit_en;

    if (POR_ONLY) begin : g_por
        assign rst_n = rst_por_n;
    end else begin : g_both
        assign rst_n = rst_por_n & rst_soft_n;
    end

    assign bit_en = lane_mask(be) & WMASK;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val = (st_q.val & ~bit_en) | (wdata & bit_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= DEF_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_q = st_q.val;

endmodule

// File: rtl/lrb_readmux.sv
module lrb_readmux
    import lrb_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd,
    input  logic [IDX_W-1:0]      idx,
    input  logic [NREG-1:0][DATA_W-1:0] regs,
    input  logic                  pend,
    output word_t                 rdata_q
);

    typedef struct packed {
        word_t rdata;
    } rd_st_t;

    rd_st_t st_d, st_q;
    word_t  sel_val;

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDX_W'(i)) sel_val = regs[i];
        end
        if (idx == IDX_W'(LOCK_SLOT)) sel_val = {{(DATA_W-1){1'b0}}, pend};
    end

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.rdata = sel_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_q = st_q.rdata;

endmodule

// File: rtl/locked_regbank.sv
module locked_regbank
    import lrb_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_soft_n,
    input  logic              rst_por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata
);

    logic                        rst_any_n;
    logic [IDX_W-1:0]            idx;
    logic [NREG-1:0]             reg_sel;
    logic                        unlock_hit;
    logic                        pend_q;
    logic [NREG-1:0][DATA_W-1:0] reg_q;

    assign rst_any_n = rst_soft_n & rst_por_n;

    lrb_decode #(
        .ADDR_W (ADDR_W),
        .IDX_LSB(IDX_LSB),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .be        (bus_be),
        .idx       (idx),
        .reg_sel   (reg_sel),
        .unlock_hit(unlock_hit)
    );

    lrb_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_any_n),
        .access    (bus_rd | bus_wr),
        .unlock_hit(unlock_hit),
        .pend_q    (pend_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic we;
        if (reg_guarded(g)) begin : g_guard
            assign we = bus_wr & reg_sel[g] & pend_q;
        end else begin : g_open
            assign we = bus_wr & reg_sel[g];
        end

        lrb_field #(.IDX(g)) u_field (
            .clk       (clk),
            .rst_soft_n(rst_soft_n),
            .rst_por_n (rst_por_n),
            .we        (we),
            .be        (bus_be),
            .wdata     (bus_wdata),
            .val_q     (reg_q[g])
        );
    end

    lrb_readmux #(.IDX_W(IDX_W)) u_readmux (
        .clk    (clk),
        .rst_n  (rst_any_n),
        .rd     (bus_rd),
        .idx    (idx),
        .regs   (reg_q),
        .pend   (pend_q),
        .rdata_q(bus_rdata)
    );

endmodule

// File: rtl/lrb_checker.sv
module lrb_checker
    import lrb_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr,
    input logic                        rd,
    input logic [ADDR_W-1:0]           addr,
    input logic [31:0]                 wdata,
    input logic [3:0]                  be,
    input logic [31:0]                 rdata,
    input logic                        pend,
    input logic [NREG-1:0][DATA_W-1:0] regs
);

    logic [IDX_W-1:0] a_idx;
    logic             a_unlock;

    assign a_idx    = addr[IDX_LSB +: IDX_W];
    assign a_unlock = wr && (a_idx == IDX_W'(LOCK_SLOT)) && (wdata == 32'h0000_00AA) && (be == 4'hF);

    for (genvar g = 0; g < NREG; g++) begin : g_rsvd
        AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[g] & ~reg_wmask(g)) == '0); // R3
    end

    AST_GUARD_REG2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a_idx == IDX_W'(2) && !pend) |=> $stable(regs[2])); // R5

    AST_GUARD_REG3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a_idx == IDX_W'(3) && !pend) |=> $stable(regs[3])); // R5

    AST_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(a_unlock)); // R6

    AST_PEND_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && (rd || wr) && !a_unlock) |=> !pend); // R6

    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a_idx == IDX_W'(0) && be == 4'hF) |=> regs[0] == ($past(wdata) & 32'h0000_FFFF)); // R6

    AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && a_idx == IDX_W'(LOCK_SLOT)) |=> rdata == {31'b0, $past(pend)}); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && a_idx > IDX_W'(LOCK_SLOT)) |=> rdata == '0); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R10

endmodule

bind locked_regbank lrb_checker #(
    .ADDR_W (ADDR_W),
    .IDX_LSB(IDX_LSB),
    .IDX_W  (IDX_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_any_n),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .be   (bus_be),
    .rdata(bus_rdata),
    .pend (pend_q),
    .regs (reg_q)
);

// File: tb/tb_locked_regbank.sv
module tb_locked_regbank;

    logic        clk = 1'b0;
    logic        rst_soft_n = 1'b0;
    logic        rst_por_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    locked_regbank dut (
        .clk       (clk),
        .rst_soft_n(rst_soft_n),
        .rst_por_n (rst_por_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    // Reference model built from the requirements
    logic [31:0] m_reg [4];
    logic        m_pend;
    logic [31:0] m_rdata;

    function automatic logic [31:0] wmask(input int i);
        case (i)
            0: return 32'h0000_FFFF;
            1: return 32'hFF00_FF0F;
            2: return 32'h0000_03FF;
            3: return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] defval(input int i);
        case (i)
            0: return 32'h0000_00A5;
            1: return 32'h0000_0F00;
            2: return 32'h0000_0001;
            default: return 32'h0000_0010;
        endcase
    endfunction

    function automatic logic [31:0] lanes(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic model_apply(input bit rd, input bit wr, input logic [11:0] a,
                               input logic [31:0] wd, input logic [3:0] be);
        int idx = int'(a[4:2]);
        logic [31:0] rv;
        logic [31:0] lm;
        bit unl;
        if (idx < 4)       rv = m_reg[idx];
        else if (idx == 4) rv = {31'b0, m_pend};
        else               rv = 32'h0;
        if (wr && idx < 4 && (idx < 2 || m_pend)) begin
            lm = lanes(be) & wmask(idx);
            m_reg[idx] = (m_reg[idx] & ~lm) | (wd & lm);
        end
        unl = wr && idx == 4 && wd == 32'h0000_00AA && be == 4'hF;
        if (rd || wr) m_pend = unl;
        if (rd) m_rdata = rv;
    endtask

    task automatic acc(input string tag, input bit rd, input bit wr, input logic [11:0] a,
                       input logic [31:0] wd, input logic [3:0] be);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; bus_be = be;
        model_apply(rd, wr, a, wd, be);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check(tag, bus_rdata, m_rdata);
    endtask

    task automatic rd_exp(input string tag, input logic [11:0] a, input logic [31:0] exp);
        acc(tag, 1'b1, 1'b0, a, 32'h0, 4'h0);
        check(tag, bus_rdata, exp);
    endtask

    task automatic soft_reset();
        @(negedge clk);
        rst_soft_n = 1'b0;
        for (int i = 0; i < 3; i++) m_reg[i] = defval(i);
        m_pend = 1'b0; m_rdata = 32'h0;
        #1 check("R1 soft reset rdata", bus_rdata, 32'h0);
        @(negedge clk);
        rst_soft_n = 1'b1;
    endtask

    task automatic por_reset();
        @(negedge clk);
        rst_por_n = 1'b0;
        for (int i = 0; i < 4; i++) m_reg[i] = defval(i);
        m_pend = 1'b0; m_rdata = 32'h0;
        #1 check("R2 por rdata", bus_rdata, 32'h0);
        @(negedge clk);
        rst_por_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] old0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_reg[i] = defval(i);
        m_pend = 1'b0; m_rdata = 32'h0;
        repeat (2) @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_por_n = 1'b1; rst_soft_n = 1'b1;

        // R1 defaults
        rd_exp("R1 reg0 default", 12'h000, 32'h0000_00A5);
        rd_exp("R1 reg1 default", 12'h004, 32'h0000_0F00);
        rd_exp("R1 reg2 default", 12'h008, 32'h0000_0001);
        rd_exp("R2 reg3 default", 12'h00C, 32'h0000_0010);
        rd_exp("R7 no pending", 12'h010, 32'h0);

        // R5 guarded write without unlock
        acc("R5", 0, 1, 12'h008, 32'h0000_0155, 4'hF);
        rd_exp("R5 locked reg2 unchanged", 12'h008, 32'h0000_0001);
        // R5 unlock then write
        acc("R5", 0, 1, 12'h010, 32'h0000_00AA, 4'hF);
        acc("R5", 0, 1, 12'h008, 32'h0000_0155, 4'hF);
        rd_exp("R5 unlocked write reg2", 12'h008, 32'h0000_0155);
        // R7 readback of pending, then R6 read cancels
        acc("R7", 0, 1, 12'h010, 32'h0000_00AA, 4'hF);
        rd_exp("R7 pending reads 1", 12'h010, 32'h1);
        acc("R6", 0, 1, 12'h00C, 32'h0000_0077, 4'hF);
        rd_exp("R6 read cancels unlock", 12'h00C, 32'h0000_0010);
        // R6 write to open reg consumes unlock
        acc("R6", 0, 1, 12'h010, 32'h0000_00AA, 4'hF);
        acc("R6", 0, 1, 12'h000, 32'h0000_1234, 4'hF);
        acc("R6", 0, 1, 12'h00C, 32'h0000_0077, 4'hF);
        rd_exp("R6 consumed by open write", 12'h00C, 32'h0000_0010);
        rd_exp("R6 open write lands", 12'h000, 32'h0000_1234);
        // R5 partial-lane unlock is not an unlock
        acc("R5", 0, 1, 12'h010, 32'h0000_00AA, 4'h1);
        rd_exp("R5 byte unlock ignored", 12'h010, 32'h0);
        // R4 byte lane
        acc("R4", 0, 1, 12'h000, 32'hFFFF_BEEF, 4'h2);
        rd_exp("R4 lane1 only", 12'h000, 32'h0000_BE34);
        // R3 reserved bits
        acc("R3", 0, 1, 12'h004, 32'hFFFF_FFFF, 4'hF);
        rd_exp("R3 reserved read zero", 12'h004, 32'hFF00_FF0F);
        // R8 unmapped
        acc("R8", 0, 1, 12'h014, 32'hFFFF_FFFF, 4'hF);
        rd_exp("R8 unmapped 0x14", 12'h014, 32'h0);
        rd_exp("R8 unmapped 0x1C", 12'h01C, 32'h0);
        rd_exp("R8 reg0 untouched", 12'h000, 32'h0000_BE34);
        // R9 aliasing
        acc("R9", 0, 1, 12'h030, 32'h0000_00AA, 4'hF);
        acc("R9", 0, 1, 12'hFEF, 32'h0000_005A, 4'hF);
        rd_exp("R9 alias reg3", 12'h80C, 32'h0000_005A);
        // R11 read and write together
        acc("R11", 1, 1, 12'h100, 32'h0000_7777, 4'hF);
        check("R11 old value returned", bus_rdata, 32'h0000_BE34);
        rd_exp("R11 write landed", 12'h000, 32'h0000_7777);
        // R10 hold
        repeat (3) @(negedge clk);
        check("R10 rdata holds", bus_rdata, 32'h0000_7777);
        // R2 soft reset keeps reg3
        soft_reset();
        rd_exp("R2 reg3 kept", 12'h00C, 32'h0000_005A);
        rd_exp("R1 reg0 after soft", 12'h000, 32'h0000_00A5);
        rd_exp("R1 reg2 after soft", 12'h008, 32'h0000_0001);
        por_reset();
        rd_exp("R2 reg3 after por", 12'h00C, 32'h0000_0010);

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            logic [11:0] a;
            logic [31:0] wd;
            logic [3:0]  be;
            logic [1:0]  op;
            a = 12'($urandom);
            if ($urandom % 3 == 0) a[4:2] = 3'd4;
            wd = ($urandom % 3 == 0) ? 32'h0000_00AA : $urandom;
            be = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
            op = 2'($urandom);
            if (op == 2'b00) op = 2'b10;
            acc("R4 R5 R6 R11 random", op[0], op[1], a, wd, be);
            if (n % 1000 == 999) soft_reset();
        end
        for (int i = 0; i < 4; i++) begin
            old0 = m_reg[i];
            rd_exp("R3 final readback", 12'(4 * i), old0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule